// File: doc/BRIEF.md
# Bus Address Error Checker

This block screens every bus access request issued by a processor core or a DMA engine and decides, before any bus cycle begins, whether the request is illegal. It looks at the address, whether the request is an instruction fetch or a data transfer, the transfer size and the requesting master. A combinational flag reports the verdict for the current request in the same cycle.

The first illegal request that arrives while the request strobe is high is captured in an exception register. That register holds the faulting address, the access kind, the size and the master, and keeps an exception request line high until software pulses an acknowledge. Illegal requests that arrive while the register is full are dropped. The bounds of the peripheral region and of the forbidden high fetch window are parameters.

Top module: `addr_err_chk`

## Requirements
- R1: Size encoding is 0 byte, 1 word, 2 longword, 3 double longword. A data access (kind input 0) fails alignment when the address is not a multiple of the size in bytes (1, 2, 4, 8). Byte accesses never fail.
- R2: Data alignment is checked the same way for master 0 (CPU) and master 1 (DMA).
- R3: A CPU instruction fetch (kind input 1, master 0) at an odd address is flagged. At an even address outside the forbidden regions it is not flagged.
- R4: A CPU instruction fetch whose address lies within the peripheral region, both bounds included, is flagged.
- R5: A CPU instruction fetch within the high window 0xF0000000 to 0xF5FFFFFF, both bounds included, is flagged.
- R6: Aligned data accesses of any size inside the peripheral region are not flagged.
- R7: A fetch request from the DMA master (kind 1, master 1) is never flagged.
- R8: `err_o` reflects the current inputs in the same cycle, whether or not the strobe is high.
- R9: When `req_i` is high and the request is illegal while no exception is pending, `exc_req_o` goes high after the next rising edge and the captured fields equal that request's values.
- R10: While an exception is pending, further illegal requests leave the captured fields unchanged.
- R11: An `ack_i` pulse clears `exc_req_o` on the next edge. A synchronous active-high reset clears it too. If an illegal request arrives in the same cycle as the acknowledge, it is captured.
- R12: An illegal request with `req_i` low is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request strobe |
| addr_i | input | 32 | Request address |
| kind_i | input | 1 | 1 = instruction fetch, 0 = data read/write |
| size_i | input | 2 | Transfer size code |
| master_i | input | 1 | 0 = CPU, 1 = DMA |
| ack_i | input | 1 | Exception acknowledge pulse |
| err_o | output | 1 | Combinational error for the current request |
| exc_req_o | output | 1 | Pending exception request |
| exc_addr_o | output | 32 | Captured faulting address |
| exc_kind_o | output | 1 | Captured access kind |
| exc_size_o | output | 2 | Captured size |
| exc_master_o | output | 1 | Captured master |

## Verification
The bench builds the block with its default parameters: a peripheral region from 0xFC000000 to 0xFFFFFFFF and a fetch window from 0xF0000000 to 0xF5FFFFFF. It probes addresses exactly at and one step beyond each bound. This reaches the inclusive edges of both regions and the gap between them, where fetches are legal. Each access size, each kind and each master is paired with aligned and misaligned offsets. These cases are mixed with acknowledge timing, so that the hold and same-cycle capture paths are also exercised.

// File: rtl/addr_err_pkg.sv
package addr_err_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_DLONG = 2'd3
  } size_e;

  typedef struct packed {
    logic [31:0] addr;
    logic        kind;
    logic [1:0]  size;
    logic        master;
  } exc_rec_t;

  // low-order address mask that must be zero for a given size code
  function automatic logic [2:0] align_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE:  return 3'b000;
      SZ_WORD:  return 3'b001;
      SZ_LONG:  return 3'b011;
      default:  return 3'b111;
    endcase
  endfunction

  function automatic logic in_range(input logic [31:0] a,
                                    input logic [31:0] lo,
                                    input logic [31:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/addr_err_align.sv
module addr_err_align
  import addr_err_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    size_i,
  input  logic          kind_i,
  output logic          misalign_o
);
  logic [2:0] mask;
  always_comb begin
    // fetches are halfword units; data uses its own size
    mask       = kind_i ? 3'b001 : align_mask(size_i);
    misalign_o = |(addr_i[2:0] & mask);
  end
endmodule

// File: rtl/addr_err_region.sv
module addr_err_region
  import addr_err_pkg::*;
#(
  parameter int          AW      = 32,
  parameter logic [31:0] PERI_LO = 32'hFC00_0000,
  parameter logic [31:0] PERI_HI = 32'hFFFF_FFFF,
  parameter logic [31:0] WIN_LO  = 32'hF000_0000,
  parameter logic [31:0] WIN_HI  = 32'hF5FF_FFFF
) (
  input  logic [AW-1:0] addr_i,
  output logic          in_peri_o,
  output logic          in_win_o
);
  always_comb begin
    in_peri_o = in_range(addr_i, PERI_LO, PERI_HI);
    in_win_o  = in_range(addr_i, WIN_LO, WIN_HI);
  end
endmodule

// File: rtl/addr_err_capture.sv
module addr_err_capture
  import addr_err_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_i,
  input  logic     load_i,
  input  logic     ack_i,
  input  exc_rec_t rec_i,
  output logic     pend_o,
  output exc_rec_t rec_o
);
  logic     pend_q;
  exc_rec_t rec_q;
  logic     free;

  assign free = !pend_q || ack_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= 1'b0;
      rec_q  <= '0;
    end else if (load_i && free) begin
      pend_q <= 1'b1;
      rec_q  <= rec_i;
    end else if (ack_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign rec_o  = rec_q;
endmodule

// File: rtl/addr_err_chk.sv
module addr_err_chk
  import addr_err_pkg::*;
#(
  parameter logic [31:0] PERI_LO = 32'hFC00_0000,
  parameter logic [31:0] PERI_HI = 32'hFFFF_FFFF,
  parameter logic [31:0] WIN_LO  = 32'hF000_0000,
  parameter logic [31:0] WIN_HI  = 32'hF5FF_FFFF
) (
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        req_i,
  input  logic [31:0] addr_i,
  input  logic        kind_i,
  input  logic [1:0]  size_i,
  input  logic        master_i,
  input  logic        ack_i,
  output logic        err_o,
  output logic        exc_req_o,
  output logic [31:0] exc_addr_o,
  output logic        exc_kind_o,
  output logic [1:0]  exc_size_o,
  output logic        exc_master_o
);
  localparam int AW = 32;

  logic     misalign_w;
  logic     in_peri_w;
  logic     in_win_w;
  logic     cpu_fetch_w;
  logic     region_err_w;
  logic     align_err_w;
  logic     capture_w;
  exc_rec_t rec_in_w;
  exc_rec_t rec_out_w;

  addr_err_align #(.AW(AW)) u_align (
    .addr_i    (addr_i),
    .size_i    (size_i),
    .kind_i    (kind_i),
    .misalign_o(misalign_w)
  );

  addr_err_region #(
    .AW(AW), .PERI_LO(PERI_LO), .PERI_HI(PERI_HI),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)
  ) u_region (
    .addr_i   (addr_i),
    .in_peri_o(in_peri_w),
    .in_win_o (in_win_w)
  );

  // fetch checks belong to the CPU only; data checks to both masters
  assign cpu_fetch_w  = kind_i && !master_i;
  assign region_err_w = cpu_fetch_w && (in_peri_w || in_win_w);
  assign align_err_w  = misalign_w && (!kind_i || cpu_fetch_w);
  assign err_o        = region_err_w || align_err_w;
  assign capture_w    = req_i && err_o;

  assign rec_in_w = '{addr: addr_i, kind: kind_i, size: size_i, master: master_i};

  addr_err_capture u_cap (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(capture_w),
    .ack_i (ack_i),
    .rec_i (rec_in_w),
    .pend_o(exc_req_o),
    .rec_o (rec_out_w)
  );

  assign exc_addr_o   = rec_out_w.addr;
  assign exc_kind_o   = rec_out_w.kind;
  assign exc_size_o   = rec_out_w.size;
  assign exc_master_o = rec_out_w.master;
endmodule

// File: rtl/addr_err_chk_sva.sv
module addr_err_chk_sva (
  input logic        clk_i,
  input logic        rst_i,
  input logic        req_i,
  input logic [31:0] addr_i,
  input logic        kind_i,
  input logic [1:0]  size_i,
  input logic        master_i,
  input logic        ack_i,
  input logic        err_o,
  input logic        exc_req_o,
  input logic [31:0] exc_addr_o
);
  // R9: an illegal strobed request with nothing pending raises the request
  a_r9_raise: assert property (@(posedge clk_i) disable iff (rst_i)
    (req_i && err_o && !exc_req_o) |=> (exc_req_o && exc_addr_o == $past(addr_i)));

  // R10: pending and not acknowledged keeps the captured address
  a_r10_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    (exc_req_o && !ack_i) |=> (exc_req_o && $stable(exc_addr_o)));

  // R11: acknowledge without a new fault drops the request
  a_r11_ack: assert property (@(posedge clk_i) disable iff (rst_i)
    (ack_i && !(req_i && err_o)) |=> !exc_req_o);

  // R12: the request only rises on a strobed fault
  a_r12_rise_src: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(exc_req_o) |-> $past(req_i && err_o));

  // R7: DMA fetches are never flagged
  a_r7_dma_fetch: assert property (@(posedge clk_i) disable iff (rst_i)
    (kind_i && master_i) |-> !err_o);

  // R6: aligned data accesses never flag
  a_r6_data_ok: assert property (@(posedge clk_i) disable iff (rst_i)
    (!kind_i && size_i == 2'd0) |-> !err_o);
endmodule

bind addr_err_chk addr_err_chk_sva u_sva (
  .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .addr_i(addr_i),
  .kind_i(kind_i), .size_i(size_i), .master_i(master_i), .ack_i(ack_i),
  .err_o(err_o), .exc_req_o(exc_req_o), .exc_addr_o(exc_addr_o)
);

// File: tb/addr_err_chk_tb_top.sv
`timescale 1ns/1ps
module addr_err_chk_tb_top;
  logic        clk = 0;
  logic        rst, req, kind, master, ack;
  logic [31:0] addr;
  logic [1:0]  size;
  logic        err;
  logic        xreq, xkind, xmaster;
  logic [31:0] xaddr;
  logic [1:0]  xsize;

  int tests = 0;
  int fails = 0;

  // reference model state
  bit        m_pend;
  bit [31:0] m_addr;
  bit        m_kind, m_master;
  bit [1:0]  m_size;

  always #5 clk = ~clk;

  addr_err_chk dut_i (
    .clk_i(clk), .rst_i(rst), .req_i(req), .addr_i(addr), .kind_i(kind),
    .size_i(size), .master_i(master), .ack_i(ack), .err_o(err),
    .exc_req_o(xreq), .exc_addr_o(xaddr), .exc_kind_o(xkind),
    .exc_size_o(xsize), .exc_master_o(xmaster)
  );

  function automatic bit ref_err(bit [31:0] a, bit k, bit [1:0] s, bit m);
    longint unsigned ua;
    int bytes;
    ua = a;
    if (k) begin
      if (m) return 0;
      if (a % 2 != 0) return 1;
      if (ua >= 64'hFC000000) return 1;
      if (ua >= 64'hF0000000 && ua <= 64'hF5FFFFFF) return 1;
      return 0;
    end
    bytes = 1 << s;
    return (a % bytes) != 0;
  endfunction

  task automatic check(string tag, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle, checking comb err mid-cycle and model after edge
  task automatic step(string tag, bit r, bit [31:0] a, bit k, bit [1:0] s, bit m, bit ac);
    bit e;
    req = r; addr = a; kind = k; size = s; master = m; ack = ac;
    #2;
    e = ref_err(a, k, s, m);
    check({tag, " err (R8)"}, err, e);
    @(posedge clk);
    if (r && e && (!m_pend || ac)) begin
      m_pend = 1; m_addr = a; m_kind = k; m_size = s; m_master = m;
    end else if (ac) m_pend = 0;
    #2;
    check({tag, " pend"}, xreq, m_pend);
    if (m_pend) begin
      check({tag, " addr"}, xaddr, m_addr);
      check({tag, " kind"}, xkind, m_kind);
      check({tag, " size"}, xsize, m_size);
      check({tag, " master"}, xmaster, m_master);
    end
    @(negedge clk);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1; req = 0; addr = 0; kind = 0; size = 0; master = 0; ack = 0;
    repeat (2) @(posedge clk);
    #1 rst = 0;
    check("reset R11", xreq, 0);
    m_pend = 0;
    @(negedge clk);
    // R1/R2 alignment, both masters, no strobe
    for (int s = 0; s < 4; s++)
      for (int off = 0; off < 8; off++)
        for (int m = 0; m < 2; m++)
          step("R1 R2 align", 0, 32'h1000 + off, 0, s[1:0], m[0], 0);
    // R3 fetch parity
    step("R3 even", 0, 32'h2000, 1, 2, 0, 0);
    step("R3 odd",  0, 32'h2001, 1, 2, 0, 0);
    // R4 peripheral bounds
    step("R4 lo",    0, 32'hFC000000, 1, 1, 0, 0);
    step("R4 below", 0, 32'hFBFFFFFE, 1, 1, 0, 0);
    step("R4 hi",    0, 32'hFFFFFFFE, 1, 1, 0, 0);
    // R5 window bounds
    step("R5 lo",    0, 32'hF0000000, 1, 1, 0, 0);
    step("R5 hi",    0, 32'hF5FFFFFE, 1, 1, 0, 0);
    step("R5 above", 0, 32'hF6000000, 1, 1, 0, 0);
    step("R5 below", 0, 32'hEFFFFFFE, 1, 1, 0, 0);
    // R6 data in peripheral space
    for (int s = 0; s < 4; s++) step("R6 peri data", 0, 32'hFC000010, 0, s[1:0], 0, 0);
    // R7 DMA fetch
    step("R7 dma odd", 0, 32'hFC000001, 1, 1, 1, 0);
    step("R7 dma win", 0, 32'hF0000000, 1, 1, 1, 0);
    // R12 unstrobed error not captured
    step("R12 nostrobe", 0, 32'h3, 0, 2, 0, 0);
    // R9 capture
    step("R9 capture", 1, 32'h1002, 0, 2, 1, 0);
    // R10 hold
    step("R10 hold", 1, 32'h2001, 1, 1, 0, 0);
    step("R10 idle", 0, 32'h0, 0, 0, 0, 0);
    // R11 ack clears
    step("R11 ack", 0, 32'h0, 0, 0, 0, 1);
    // R11 ack with simultaneous fault captures
    step("R9 cap2", 1, 32'hF0000004, 1, 1, 0, 0);
    step("R11 ack+fault", 1, 32'h1006, 0, 3, 0, 1);
    step("R11 ack2", 0, 32'h0, 0, 0, 0, 1);
    // R11 reset clears
    step("R9 cap3", 1, 32'h5, 0, 1, 0, 0);
    rst = 1; @(posedge clk); #1 rst = 0; m_pend = 0;
    check("R11 reset clear", xreq, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule